// File: doc/BRIEF.md
# Descending Link Chain Initialiser

This engine prepares an empty ordering table in word-addressed memory. On a command it writes a run of words that starts at a given byte address and walks down one word (four bytes) per write. Every word except the last holds the byte address of the word written right after it, that is the next lower word. The last word holds a fixed end-of-chain marker. The result is a linked list that can be followed from the highest address to the lowest, where each entry is still empty.

Each command carries a start strobe, a base byte address and a word count. The engine has a single write port with a valid/ready handshake. It raises a busy flag for the whole run and a pending-trigger flag for the one cycle between taking the command and issuing the first write. One cycle after the last write is accepted it pulses done. Every address is folded into the memory size by a mask that also clears the two low bits, so a chain that passes address zero continues from the top word of the memory. The memory size is a parameter.

Top module: `chain_init_engine`

## Requirements
- R1: During and directly after reset, busy, trig_pend, mem_wr_valid and done are all 0.
- R2: A cmd_start seen at a clock edge while idle sets busy and trig_pend at that edge. At the next edge trig_pend clears and mem_wr_valid rises with the first write.
- R3: The first write goes to cmd_base AND MASK, where MASK is (MEM_BYTES − 1) with bits 1:0 forced to 0 (0xFC when MEM_BYTES = 256).
- R4: Each later write goes to the previous write address minus 4, ANDed with MASK, so address 0 is followed by MEM_BYTES − 4.
- R5: Every write except the last carries the value (its own address − 4) AND MASK, which is the address of the next write.
- R6: The last write of a command carries 0x00FFFFFF. A count of 1 produces exactly one write, and that write carries this value.
- R7: A cmd_count of 0 produces 2^COUNT_W writes (65536 by default). Any other count n produces exactly n writes.
- R8: While mem_wr_valid is 1 and mem_wr_ready is 0, the address and data stay unchanged and valid stays 1. The engine moves on only after a handshake.
- R9: done is a one-cycle pulse in the cycle after the last write is accepted. busy and mem_wr_valid are already 0 in that cycle.
- R10: A cmd_start while busy is ignored. The running command neither restarts nor changes, and no new command follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | Command strobe, taken only when idle |
| cmd_base | input | 32 | Byte address of the highest (first) word |
| cmd_count | input | COUNT_W | Number of words; 0 means 2^COUNT_W |
| busy | output | 1 | High from command acceptance until the last write is accepted |
| trig_pend | output | 1 | High for the cycle between acceptance and the first write |
| mem_wr_valid | output | 1 | Write request valid |
| mem_wr_addr | output | 32 | Write byte address, word aligned |
| mem_wr_data | output | 32 | Write data: link address or end marker |
| mem_wr_ready | input | 1 | Memory accepts the write at this edge |
| done | output | 1 | One-cycle completion pulse |

## Verification
Errors in the address register show up at the first write after them. A missed decrement or a missing mask lets the next address differ from the data of the write before it, so the chain link breaks in the following cycle. A word counter that is off by one moves the end marker to the wrong word and moves the done pulse by a whole handshake. An FSM that advances without ready changes address or data during a stall in the very next cycle. The bench sweeps every word-aligned base of a small memory, with low address bits set, through wrap-around and under irregular ready patterns, and predicts every address and data value by arithmetic.

// File: rtl/chain_init_pkg.sv
package chain_init_pkg;

    localparam int unsigned CI_WORD_W = 32;
    localparam logic [CI_WORD_W-1:0] CI_END_MARK = 32'h00FF_FFFF;
    localparam logic [CI_WORD_W-1:0] CI_STEP     = 32'd4;

    typedef enum logic [1:0] {
        CI_IDLE  = 2'd0,
        CI_ARM   = 2'd1,
        CI_WRITE = 2'd2
    } ci_state_e;

    typedef struct packed {
        logic [CI_WORD_W-1:0] addr;
        logic [CI_WORD_W-1:0] data;
    } ci_beat_t;

    function automatic logic [CI_WORD_W-1:0] ci_addr_mask(input longint unsigned mem_bytes);
        logic [CI_WORD_W-1:0] m;
        m = CI_WORD_W'(mem_bytes - 1);
        m[1:0] = 2'b00;
        return m;
    endfunction

endpackage

// File: rtl/chain_addr_step.sv
module chain_addr_step
    import chain_init_pkg::*;
#(
    parameter longint unsigned MEM_BYTES = 2097152
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic [CI_WORD_W-1:0] load_base,
    input  logic                 advance,
    output logic [CI_WORD_W-1:0] cur_addr,
    output logic [CI_WORD_W-1:0] next_addr
);
    localparam logic [CI_WORD_W-1:0] MASK = ci_addr_mask(MEM_BYTES);

    logic [CI_WORD_W-1:0] addr_q;

    always_comb begin
        next_addr = (addr_q - CI_STEP) & MASK;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
        end else if (load) begin
            addr_q <= load_base & MASK;
        end else if (advance) begin
            addr_q <= next_addr;
        end
    end

    assign cur_addr = addr_q;

endmodule

// File: rtl/chain_word_cnt.sv
module chain_word_cnt #(
    parameter int unsigned COUNT_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [COUNT_W-1:0] load_count,
    input  logic               advance,
    output logic               is_last
);
    localparam logic [COUNT_W:0] ONE     = {{COUNT_W{1'b0}}, 1'b1};
    localparam logic [COUNT_W:0] MAX_CNT = {1'b1, {COUNT_W{1'b0}}};

    logic [COUNT_W:0] rem_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
        end else if (load) begin
            rem_q <= (load_count == '0) ? MAX_CNT : {1'b0, load_count};
        end else if (advance) begin
            rem_q <= rem_q - ONE;
        end
    end

    assign is_last = (rem_q == ONE);

endmodule

// File: rtl/chain_ctrl.sv
module chain_ctrl
    import chain_init_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic is_last,
    input  logic wr_ready,
    output logic load,
    output logic advance,
    output logic wr_valid,
    output logic busy,
    output logic trig_pend,
    output logic done
);
    ci_state_e state_q;
    logic      done_q;

    always_comb begin
        load      = (state_q == CI_IDLE) && start;
        wr_valid  = (state_q == CI_WRITE);
        advance   = wr_valid && wr_ready;
        busy      = (state_q != CI_IDLE);
        trig_pend = (state_q == CI_ARM);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CI_IDLE;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                CI_IDLE: begin
                    if (start) begin
                        state_q <= CI_ARM;
                    end
                end
                CI_ARM: begin
                    state_q <= CI_WRITE;
                end
                CI_WRITE: begin
                    if (wr_ready && is_last) begin
                        state_q <= CI_IDLE;
                        done_q  <= 1'b1;
                    end
                end
                default: begin
                    state_q <= CI_IDLE;
                end
            endcase
        end
    end

    assign done = done_q;

endmodule

// File: rtl/chain_init_engine.sv
module chain_init_engine
    import chain_init_pkg::*;
#(
    parameter longint unsigned MEM_BYTES = 2097152,
    parameter int unsigned     COUNT_W   = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cmd_start,
    input  logic [CI_WORD_W-1:0] cmd_base,
    input  logic [COUNT_W-1:0]   cmd_count,
    output logic                 busy,
    output logic                 trig_pend,
    output logic                 mem_wr_valid,
    output logic [CI_WORD_W-1:0] mem_wr_addr,
    output logic [CI_WORD_W-1:0] mem_wr_data,
    input  logic                 mem_wr_ready,
    output logic                 done
);
    logic                 load;
    logic                 advance;
    logic                 is_last;
    logic [CI_WORD_W-1:0] cur_addr;
    logic [CI_WORD_W-1:0] next_addr;
    ci_beat_t             beat;

    chain_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (cmd_start),
        .is_last   (is_last),
        .wr_ready  (mem_wr_ready),
        .load      (load),
        .advance   (advance),
        .wr_valid  (mem_wr_valid),
        .busy      (busy),
        .trig_pend (trig_pend),
        .done      (done)
    );

    chain_addr_step #(.MEM_BYTES(MEM_BYTES)) u_addr (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .load_base (cmd_base),
        .advance   (advance),
        .cur_addr  (cur_addr),
        .next_addr (next_addr)
    );

    chain_word_cnt #(.COUNT_W(COUNT_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .load       (load),
        .load_count (cmd_count),
        .advance    (advance),
        .is_last    (is_last)
    );

    // Link value is the next address; the final word gets the end marker.
    always_comb begin
        beat.addr = cur_addr;
        beat.data = is_last ? CI_END_MARK : next_addr;
    end

    assign mem_wr_addr = beat.addr;
    assign mem_wr_data = beat.data;

endmodule

// File: rtl/chain_init_chk.sv
module chain_init_chk
    import chain_init_pkg::*;
#(
    parameter longint unsigned MEM_BYTES = 2097152
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 busy,
    input logic                 trig_pend,
    input logic                 mem_wr_valid,
    input logic                 mem_wr_ready,
    input logic [CI_WORD_W-1:0] mem_wr_addr,
    input logic [CI_WORD_W-1:0] mem_wr_data,
    input logic                 done
);
    localparam logic [CI_WORD_W-1:0] MASK = ci_addr_mask(MEM_BYTES);

    // R8
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_valid && !mem_wr_ready) |=>
            (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data)));

    // R5
    chain_link_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_valid && mem_wr_ready && mem_wr_data != CI_END_MARK) |=>
            (mem_wr_valid && mem_wr_addr == $past(mem_wr_data)));

    // R3
    addr_range_chk: assert property (@(posedge clk) disable iff (rst)
        mem_wr_valid |-> ((mem_wr_addr & ~MASK) == '0));

    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && !mem_wr_valid));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    finish_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_valid && mem_wr_ready && mem_wr_data == CI_END_MARK) |=> done);

    // R2
    trig_once_chk: assert property (@(posedge clk) disable iff (rst)
        trig_pend |=> (!trig_pend && mem_wr_valid && busy));

endmodule

bind chain_init_engine chain_init_chk #(.MEM_BYTES(MEM_BYTES)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .busy         (busy),
    .trig_pend    (trig_pend),
    .mem_wr_valid (mem_wr_valid),
    .mem_wr_ready (mem_wr_ready),
    .mem_wr_addr  (mem_wr_addr),
    .mem_wr_data  (mem_wr_data),
    .done         (done)
);

// File: tb/sim_chain_init_engine.sv
module sim_chain_init_engine;

    localparam int unsigned CW   = 16;
    localparam logic [31:0] MSK  = 32'h0000_00FC;
    localparam logic [31:0] TERM = 32'h00FF_FFFF;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_start = 1'b0;
    logic [31:0]   cmd_base = '0;
    logic [CW-1:0] cmd_count = '0;
    logic          mem_wr_ready = 1'b0;
    logic          busy, trig_pend, mem_wr_valid, done;
    logic [31:0]   mem_wr_addr, mem_wr_data;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    always #5 clk = ~clk;

    chain_init_engine #(.MEM_BYTES(256), .COUNT_W(CW)) u0 (
        .clk          (clk),
        .rst          (rst),
        .cmd_start    (cmd_start),
        .cmd_base     (cmd_base),
        .cmd_count    (cmd_count),
        .busy         (busy),
        .trig_pend    (trig_pend),
        .mem_wr_valid (mem_wr_valid),
        .mem_wr_addr  (mem_wr_addr),
        .mem_wr_data  (mem_wr_data),
        .mem_wr_ready (mem_wr_ready),
        .done         (done)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic run_cmd(input logic [31:0] base, input int cnt, input int mode, input bit poke);
        logic [31:0] ea;
        logic [31:0] pa;
        logic [31:0] pd;
        int rem;
        int total;
        int want;
        int guard;
        bit stall;
        ea = base & MSK;
        want = (cnt == 0) ? 65536 : cnt;
        rem = want;
        total = 0;
        guard = 0;
        stall = 1'b0;
        pa = '0;
        pd = '0;
        @(negedge clk);
        cmd_base = base;
        cmd_count = CW'(cnt);
        cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        cmd_base = 32'hDEAD_BEEF;
        cmd_count = CW'(7);
        chk(busy && trig_pend && !mem_wr_valid, "R2 accepted",
            {29'd0, busy, trig_pend, mem_wr_valid}, 32'd6);
        @(negedge clk);
        chk(!trig_pend && mem_wr_valid && busy, "R2 trigger cleared at first write",
            {29'd0, busy, trig_pend, mem_wr_valid}, 32'd5);
        while (!done && guard < 150000) begin
            if (poke && total == 1) begin
                cmd_start = 1'b1;
                cmd_base = 32'h0000_0040;
                cmd_count = CW'(3);
            end else begin
                cmd_start = 1'b0;
            end
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            mem_wr_ready = (mode == 0) ? 1'b1 : (lfsr[0] | lfsr[3]);
            if (stall) begin
                chk(mem_wr_valid && mem_wr_addr == pa, "R8 address held", mem_wr_addr, pa);
                chk(mem_wr_data == pd, "R8 data held", mem_wr_data, pd);
            end
            if (mem_wr_valid && mem_wr_ready) begin
                if (total == 0)
                    chk(mem_wr_addr == ea, "R3 first address", mem_wr_addr, ea);
                else
                    chk(mem_wr_addr == ea, "R4 step address", mem_wr_addr, ea);
                if (rem == 1)
                    chk(mem_wr_data == TERM, "R6 end marker", mem_wr_data, TERM);
                else
                    chk(mem_wr_data == ((ea - 32'd4) & MSK), "R5 link value",
                        mem_wr_data, (ea - 32'd4) & MSK);
                ea = (ea - 32'd4) & MSK;
                rem--;
                total++;
                stall = 1'b0;
            end else begin
                stall = mem_wr_valid;
                pa = mem_wr_addr;
                pd = mem_wr_data;
            end
            @(negedge clk);
            guard++;
        end
        cmd_start = 1'b0;
        mem_wr_ready = 1'b0;
        if (cnt == 0)
            chk(total == want, "R7 zero count gives maximum", total, want);
        else if (cnt == 1)
            chk(total == want, "R6 single word run", total, want);
        else
            chk(total == want, "R7 write count", total, want);
        chk(done && !busy && !mem_wr_valid, "R9 done with engine idle",
            {29'd0, done, busy, mem_wr_valid}, 32'd4);
        @(negedge clk);
        if (poke)
            chk(!done && !busy && !mem_wr_valid, "R10 start while busy ignored",
                {29'd0, done, busy, mem_wr_valid}, 32'd0);
        else
            chk(!done && !busy && !mem_wr_valid, "R9 done lasts one cycle",
                {29'd0, done, busy, mem_wr_valid}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !trig_pend && !mem_wr_valid && !done, "R1 outputs in reset",
            {28'd0, busy, trig_pend, mem_wr_valid, done}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !trig_pend && !mem_wr_valid && !done, "R1 outputs after reset",
            {28'd0, busy, trig_pend, mem_wr_valid, done}, 32'd0);

        run_cmd(32'h0000_0010, 1, 0, 1'b0);
        run_cmd(32'h0000_0000, 4, 0, 1'b0);
        run_cmd(32'h1234_5677, 5, 1, 1'b0);
        run_cmd(32'h0000_0080, 10, 1, 1'b1);

        for (int b = 0; b < 64; b++) begin
            for (int k = 0; k < 4; k++) begin
                int n;
                n = (k == 3) ? 65 : (k + 1);
                run_cmd(32'(b * 4 + (b % 4)), n, 1, 1'b0);
            end
        end

        run_cmd(32'h0000_0020, 0, 0, 1'b0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule